// File: doc/BRIEF.md
# Selector-Indexed Configuration Item Port

This block lets a host fetch configuration items by number. The host first writes a 16-bit selector that names one entry, in either a generic table or an architecture-local table. It then reads the entry's bytes through a data register, and each read may be 1 to 8 bytes wide. An offset pointer tracks the host's position inside the selected entry. The pointer returns to zero on every select and advances by one for each byte delivered. Item bytes and per-entry lengths live in an internal store that a separate initialisation port fills before the host starts using the block.

Host accesses go through a single request channel. Each request carries a register choice (control or data), a byte offset, an access size and write data. A strap input chooses between two decodes. In split mode, control and data are separate registers. In narrow mode, one register carries both: a 1-byte access is a data access and a 2-byte write is a select. A rejected request has no effect and raises a one-cycle error pulse. A read is served one byte per cycle from a block-RAM-style store. The result comes back as a single response pulse, and the request channel is held off until then.

Top module: `cfgsel_port`

## Requirements
- R1: After reset, the generic entry with index 0 is selected at offset 0. A read with no prior select returns that entry's first bytes.
- R2: Every accepted select sets the read offset back to zero, so selecting the same entry again restarts its byte stream.
- R3: The entry index is selector bits [13:0], and bit 14 is ignored. An index at or above the entry count (default 16) makes the selection invalid, and every later read returns zero until the next valid select.
- R4: Selector bit 15 set picks the architecture-local table and clear picks the generic table. The two tables hold independent data for the same index.
- R5: A read of N bytes (1 to 8) returns them in stream order, first byte most significant, in the low N bytes of `rsp_data`, with the bits above cleared. The offset advances by the number of bytes delivered.
- R6: When the entry runs out during a read, the missing low bytes are zero. Reads with the offset at the entry's length, or of an entry of length 0, return zero.
- R7: A data-register write is accepted without error and changes nothing. A later read continues from the same offset.
- R8: In narrow mode (`narrow_mode`=1), any 1-byte access is a data access and a 2-byte write is a select, whatever the register and offset fields hold. Every other width or direction is rejected.
- R9: In split mode, the control register (`acc_reg`=0) accepts only 2-byte writes. The data register (`acc_reg`=1) accepts only sizes 1 to 8 at offset 0. A rejected request pulses `acc_err` one cycle after acceptance and leaves selection and offset unchanged.
- R10: Once a read is accepted, `acc_ready` stays low until the response. Each accepted read yields exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_mode | input | 1 | 1 selects the combined single-register decode |
| init_len_we | input | 1 | Write `init_len` as the length of the addressed entry |
| init_byte_we | input | 1 | Write `init_byte` into the addressed entry |
| init_local | input | 1 | Initialisation table choice (1 = local) |
| init_index | input | 4 | Initialisation entry index |
| init_byte_pos | input | 4 | Byte position inside the entry |
| init_byte | input | 8 | Byte value to store |
| init_len | input | 5 | Entry length in bytes (0 to 16) |
| acc_valid | input | 1 | Host request present |
| acc_ready | output | 1 | Block can take a request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 1 | 0 = control register, 1 = data register |
| acc_addr | input | 3 | Byte offset within the register |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Write data (selector value for selects) |
| acc_err | output | 1 | One-cycle pulse for a rejected request |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 64 | Read result, low `acc_size` bytes meaningful |

## Verification
The bench aims at the point where an entry runs dry in the middle of a read. A design that padded on the wrong side or kept advancing past the length would return shifted or stale bytes. It selects indices just past the last valid entry and sets the ignored bit 14. Each of these would expose a decoder that compared unmasked bits or wrapped the index. It also mixes table choices for the same index, which would expose a design that dropped bit 15. It interleaves data writes and malformed requests in both decodes between reads, so a design that let any of them disturb the offset would break the following read's byte stream.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

  localparam int MAX_ACCESS_BYTES = 8;
  localparam logic REG_CONTROL = 1'b0;
  localparam logic REG_DATA    = 1'b1;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SELECT,
    ACT_READ,
    ACT_DROP,
    ACT_REJECT
  } act_e;

endpackage

// File: rtl/cfgsel_decode.sv
module cfgsel_decode
  import cfgsel_pkg::*;
(
  input  logic       req,
  input  logic       narrow,
  input  logic       is_write,
  input  logic       reg_sel,
  input  logic [2:0] offset,
  input  logic [3:0] size,
  output act_e       act
);

  always_comb begin
    act = ACT_NONE;
    if (req) begin
      if (narrow) begin
        if (size == 4'd1)
          act = is_write ? ACT_DROP : ACT_READ;
        else if (size == 4'd2 && is_write)
          act = ACT_SELECT;
        else
          act = ACT_REJECT;
      end else if (reg_sel == REG_CONTROL) begin
        act = (is_write && size == 4'd2) ? ACT_SELECT : ACT_REJECT;
      end else begin
        if (offset == 3'd0 && size >= 4'd1 && size <= 4'(MAX_ACCESS_BYTES))
          act = is_write ? ACT_DROP : ACT_READ;
        else
          act = ACT_REJECT;
      end
    end
  end

endmodule

// File: rtl/cfgsel_store.sv
module cfgsel_store #(
  parameter int NENT   = 16,
  parameter int EBYTES = 16,
  localparam int IW = $clog2(NENT),
  localparam int PW = $clog2(EBYTES),
  localparam int LW = $clog2(EBYTES + 1),
  localparam int AW = 1 + IW + PW,
  localparam int DEPTH = 2 * NENT * EBYTES,
  localparam int NLEN = 2 * NENT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_len_we,
  input  logic          ld_byte_we,
  input  logic          ld_local,
  input  logic [IW-1:0] ld_idx,
  input  logic [PW-1:0] ld_pos,
  input  logic [7:0]    ld_byte,
  input  logic [LW-1:0] ld_len,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q,
  input  logic          lk_local,
  input  logic [IW-1:0] lk_idx,
  output logic [LW-1:0] lk_len
);

  logic [7:0] mem [DEPTH];
  logic [LW-1:0] len_q [NLEN];

  always_ff @(posedge clk) begin
    if (ld_byte_we)
      mem[{ld_local, ld_idx, ld_pos}] <= ld_byte;
    if (rd_en)
      rd_q <= mem[rd_addr];
  end

  for (genvar e = 0; e < NLEN; e++) begin : g_len
    always_ff @(posedge clk) begin
      if (rst)
        len_q[e] <= '0;
      else if (ld_len_we && {ld_local, ld_idx} == (1 + IW)'(e))
        len_q[e] <= ld_len;
    end
  end

  assign lk_len = len_q[{lk_local, lk_idx}];

endmodule

// File: rtl/cfgsel_engine.sv
module cfgsel_engine #(
  parameter int NENT      = 16,
  parameter int EBYTES    = 16,
  parameter int SELW      = 16,
  parameter int LOCAL_BIT = 15,
  parameter int IDXF      = 14,
  localparam int IW = $clog2(NENT),
  localparam int PW = $clog2(EBYTES),
  localparam int LW = $clog2(EBYTES + 1),
  localparam int AW = 1 + IW + PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_fire,
  input  logic [SELW-1:0] sel_val,
  input  logic            rd_fire,
  input  logic [3:0]      rd_size,
  input  logic [LW-1:0]   lk_len,
  input  logic [7:0]      rd_q,
  output logic            busy,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic            cur_local,
  output logic [IW-1:0]   cur_idx,
  output logic            cur_ok,
  output logic [31:0]     off,
  output logic [3:0]      size_r,
  output logic            rsp_valid,
  output logic [63:0]     rsp_data
);

  logic            run, pend;
  logic [3:0]      rem, taken;
  logic [63:0]     acc;
  logic [IDXF-1:0] masked;
  logic            sel_ok, more, iss, fin;
  logic [6:0]      pad_bits;

  assign masked   = sel_val[IDXF-1:0];
  assign sel_ok   = 32'(masked) < 32'(NENT);
  assign more     = cur_ok && (off < 32'(lk_len));
  assign iss      = run && (rem != 4'd0) && more;
  assign fin      = run && !iss && !pend;
  assign pad_bits = {size_r - taken, 3'b000};

  assign busy    = run;
  assign rd_en   = iss;
  assign rd_addr = {cur_local, cur_idx, off[PW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_local <= 1'b0;
      cur_idx   <= '0;
      cur_ok    <= 1'b1;
      off       <= '0;
      run       <= 1'b0;
      pend      <= 1'b0;
      rem       <= '0;
      taken     <= '0;
      size_r    <= '0;
      acc       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (sel_fire) begin
        cur_local <= sel_val[LOCAL_BIT];
        cur_idx   <= masked[IW-1:0];
        cur_ok    <= sel_ok;
        off       <= '0;
      end
      if (rd_fire) begin
        run    <= 1'b1;
        rem    <= rd_size;
        size_r <= rd_size;
        taken  <= '0;
        acc    <= '0;
        pend   <= 1'b0;
      end
      if (run) begin
        pend <= iss;
        if (pend)
          acc <= {acc[55:0], rd_q};
        if (iss) begin
          off   <= off + 32'd1;
          rem   <= rem - 4'd1;
          taken <= taken + 4'd1;
        end
        if (fin) begin
          run       <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= acc << pad_bits;
        end
      end
    end
  end

endmodule

// File: rtl/cfgsel_port.sv
module cfgsel_port
  import cfgsel_pkg::*;
#(
  parameter int FIRST_FILE = 8,
  parameter int FILE_SLOTS = 8,
  parameter int EBYTES     = 16,
  localparam int NENT = FIRST_FILE + FILE_SLOTS,
  localparam int IW   = $clog2(NENT),
  localparam int PW   = $clog2(EBYTES),
  localparam int LW   = $clog2(EBYTES + 1),
  localparam int AW   = 1 + IW + PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow_mode,
  input  logic          init_len_we,
  input  logic          init_byte_we,
  input  logic          init_local,
  input  logic [IW-1:0] init_index,
  input  logic [PW-1:0] init_byte_pos,
  input  logic [7:0]    init_byte,
  input  logic [LW-1:0] init_len,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic          acc_reg,
  input  logic [2:0]    acc_addr,
  input  logic [3:0]    acc_size,
  input  logic [15:0]   acc_wdata,
  output logic          acc_err,
  output logic          rsp_valid,
  output logic [63:0]   rsp_data
);

  act_e          act;
  logic          busy, rd_en, cur_local, eng_ok;
  logic [AW-1:0] rd_addr;
  logic [IW-1:0] cur_idx;
  logic [7:0]    rd_q;
  logic [LW-1:0] lk_len;
  logic [31:0]   eng_off;
  logic [3:0]    eng_size;
  logic          sel_fire, rd_fire, drop_fire, bad_fire;

  assign acc_ready = !busy;

  cfgsel_decode u_dec (
    .req      (acc_valid && acc_ready),
    .narrow   (narrow_mode),
    .is_write (acc_write),
    .reg_sel  (acc_reg),
    .offset   (acc_addr),
    .size     (acc_size),
    .act      (act)
  );

  assign sel_fire  = (act == ACT_SELECT);
  assign rd_fire   = (act == ACT_READ);
  assign drop_fire = (act == ACT_DROP);
  assign bad_fire  = (act == ACT_REJECT);

  always_ff @(posedge clk) begin
    if (rst) acc_err <= 1'b0;
    else     acc_err <= bad_fire;
  end

  cfgsel_store #(.NENT(NENT), .EBYTES(EBYTES)) u_store (
    .clk        (clk),
    .rst        (rst),
    .ld_len_we  (init_len_we),
    .ld_byte_we (init_byte_we),
    .ld_local   (init_local),
    .ld_idx     (init_index),
    .ld_pos     (init_byte_pos),
    .ld_byte    (init_byte),
    .ld_len     (init_len),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_q       (rd_q),
    .lk_local   (cur_local),
    .lk_idx     (cur_idx),
    .lk_len     (lk_len)
  );

  cfgsel_engine #(.NENT(NENT), .EBYTES(EBYTES)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sel_fire  (sel_fire),
    .sel_val   (acc_wdata),
    .rd_fire   (rd_fire),
    .rd_size   (acc_size),
    .lk_len    (lk_len),
    .rd_q      (rd_q),
    .busy      (busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .cur_local (cur_local),
    .cur_idx   (cur_idx),
    .cur_ok    (eng_ok),
    .off       (eng_off),
    .size_r    (eng_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/cfgsel_port_chk.sv
module cfgsel_port_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_ready,
  input logic          rsp_valid,
  input logic [63:0]   rsp_data,
  input logic          sel_fire,
  input logic          rd_fire,
  input logic          drop_fire,
  input logic          bad_fire,
  input logic          eng_ok,
  input logic [31:0]   eng_off,
  input logic [3:0]    eng_size,
  input logic [LW-1:0] lk_len
);

  AST_SEL_CLEARS_OFF: assert property (@(posedge clk) disable iff (rst)
    sel_fire |=> (eng_off == 32'd0)); // R2

  AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !eng_ok) |-> (rsp_data == 64'd0)); // R3

  AST_RSP_FITS_SIZE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_data >> {eng_size, 3'b000}) == 64'd0)); // R5

  AST_OFF_WITHIN_LEN: assert property (@(posedge clk) disable iff (rst)
    eng_ok |-> (eng_off <= 32'(lk_len))); // R6

  AST_DROP_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
    drop_fire |=> $stable(eng_off)); // R7

  AST_REJECT_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
    bad_fire |=> $stable(eng_off)); // R9

  AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> !acc_ready); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10

endmodule

bind cfgsel_port cfgsel_port_chk #(.LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_ready (acc_ready),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .sel_fire  (sel_fire),
  .rd_fire   (rd_fire),
  .drop_fire (drop_fire),
  .bad_fire  (bad_fire),
  .eng_ok    (eng_ok),
  .eng_off   (eng_off),
  .eng_size  (eng_size),
  .lk_len    (lk_len)
);

// File: tb/cfgsel_port_test.sv
`timescale 1ns/1ps
module cfgsel_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        narrow_mode = 1'b0;
  logic        init_len_we = 1'b0, init_byte_we = 1'b0, init_local = 1'b0;
  logic [3:0]  init_index = '0, init_byte_pos = '0;
  logic [7:0]  init_byte = '0;
  logic [4:0]  init_len = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_reg = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [3:0]  acc_size = '0;
  logic [15:0] acc_wdata = '0;
  logic        acc_ready, acc_err, rsp_valid;
  logic [63:0] rsp_data;

  always #10 clk = ~clk;

  cfgsel_port uut (
    .clk(clk), .rst(rst), .narrow_mode(narrow_mode),
    .init_len_we(init_len_we), .init_byte_we(init_byte_we),
    .init_local(init_local), .init_index(init_index),
    .init_byte_pos(init_byte_pos), .init_byte(init_byte), .init_len(init_len),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_reg(acc_reg), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_err(acc_err),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] mdat [2][16][16];
  int         mlen [2][16];
  int         m_local, m_idx, m_off;
  bit         m_ok;

  task automatic chk(string req, logic [63:0] actual, logic [63:0] expect_v);
    checks++;
    if (actual !== expect_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expect_v);
    end
  endtask

  function automatic logic [63:0] model_read(int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (m_ok && m_off < mlen[m_local][m_idx]) begin
        v = {v[55:0], mdat[m_local][m_idx][m_off]};
        m_off++;
      end else begin
        v = {v[55:0], 8'h00};
      end
    end
    return v;
  endfunction

  function automatic bit model_reject(bit wr, bit rg, int addr, int size);
    if (narrow_mode) return !((size == 1) || (size == 2 && wr));
    if (rg == 1'b0) return !(wr && size == 2);
    return !(addr == 0 && size >= 1 && size <= 8);
  endfunction

  function automatic bit model_is_select(bit wr, bit rg, int size);
    if (narrow_mode) return (size == 2 && wr);
    return (rg == 1'b0);
  endfunction

  task automatic access(bit wr, bit rg, int addr, int size, logic [15:0] wd, string req);
    bit bad;
    logic [63:0] e;
    while (!acc_ready) @(negedge clk);
    bad = model_reject(wr, rg, addr, size);
    acc_valid = 1'b1; acc_write = wr; acc_reg = rg;
    acc_addr = 3'(addr); acc_size = 4'(size); acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " error flag"}, 64'(acc_err), 64'(bad));
    if (!bad) begin
      if (model_is_select(wr, rg, size)) begin
        m_local = int'(wd[15]);
        m_ok    = (wd[13:0] < 14'd16);
        m_idx   = int'(wd[3:0]);
        m_off   = 0;
      end else if (!wr) begin
        e = model_read(size);
        chk("R10 ready low while read runs", 64'(acc_ready), 64'd0);
        while (!rsp_valid) @(negedge clk);
        chk({req, " read data"}, rsp_data, e);
      end
    end
  endtask

  task automatic sel(logic [15:0] s, string req);
    if (narrow_mode) access(1'b1, 1'b1, 0, 2, s, req);
    else             access(1'b1, 1'b0, 0, 2, s, req);
  endtask

  task automatic rd(int n, string req);
    access(1'b0, 1'b1, 0, n, 16'h0, req);
  endtask

  task automatic load_store();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 16; i++) begin
        for (int p = 0; p < 16; p++) begin
          mdat[t][i][p] = 8'($urandom);
          init_byte_we = 1'b1; init_local = t[0]; init_index = 4'(i);
          init_byte_pos = 4'(p); init_byte = mdat[t][i][p];
          @(negedge clk);
        end
        init_byte_we = 1'b0;
        mlen[t][i] = int'($urandom % 17);
        if (t == 0 && i == 0) mlen[t][i] = 16;
        if (t == 0 && i == 2) mlen[t][i] = 0;
        if (t == 0 && i == 5) mlen[t][i] = 10;
        if (t == 1 && i == 5) mlen[t][i] = 3;
        init_len_we = 1'b1; init_local = t[0]; init_index = 4'(i);
        init_len = 5'(mlen[t][i]);
        @(negedge clk);
        init_len_we = 1'b0;
      end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_local = 0; m_idx = 0; m_off = 0; m_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", 64'(acc_ready), 64'd1);
    chk("R1 reset no response", 64'(rsp_valid), 64'd0);
    chk("R1 reset no error", 64'(acc_err), 64'd0);
    load_store();

    rd(4, "R1 signature read after reset");
    rd(8, "R5 eight byte read");
    rd(2, "R5 two byte read");
    sel(16'h0000, "R2 reselect");
    rd(3, "R2 restart from zero");
    sel(16'h8005, "R4 local select");
    rd(8, "R6 short entry padded");
    rd(1, "R6 read past end");
    sel(16'h0005, "R4 generic select");
    rd(4, "R4 generic data");
    sel(16'h4005, "R3 bit14 ignored");
    rd(4, "R3 bit14 ignored data");
    sel(16'h0010, "R3 first invalid index");
    rd(4, "R3 invalid reads zero");
    sel(16'h000F, "R3 last valid index");
    rd(4, "R3 last valid data");
    sel(16'h3FFF, "R3 masked high invalid");
    rd(8, "R3 masked high invalid zero");
    sel(16'h0002, "R6 empty entry");
    rd(8, "R6 empty entry zero");
    sel(16'h0000, "R7 setup");
    rd(2, "R7 before write");
    access(1'b1, 1'b1, 0, 4, 16'hBEEF, "R7 data write ignored");
    rd(2, "R7 offset kept after write");
    access(1'b0, 1'b0, 0, 2, 16'h0, "R9 control read rejected");
    access(1'b1, 1'b0, 0, 4, 16'h0005, "R9 control wide write rejected");
    access(1'b0, 1'b1, 3, 1, 16'h0, "R9 data offset rejected");
    access(1'b0, 1'b1, 0, 9, 16'h0, "R9 data size rejected");
    rd(2, "R9 offset kept after rejects");

    narrow_mode = 1'b1;
    sel(16'h8003, "R8 narrow select");
    access(1'b0, 1'b0, 5, 1, 16'h0, "R8 narrow byte read any field");
    access(1'b0, 1'b1, 0, 2, 16'h0, "R8 narrow wide read rejected");
    access(1'b1, 1'b1, 0, 4, 16'h0001, "R8 narrow wide write rejected");
    access(1'b1, 1'b0, 0, 1, 16'h00AA, "R8 narrow byte write ignored");
    rd(1, "R8 narrow read continues");

    for (int k = 0; k < 400; k++) begin
      int r;
      if (k % 100 == 0) narrow_mode = k[7];
      r = int'($urandom % 10);
      if (r < 3) begin
        logic [15:0] s;
        s = {1'($urandom), 1'($urandom), 14'($urandom % 20)};
        sel(s, "R3 R4 random select");
      end else if (r < 7) begin
        if (narrow_mode) rd(1, "R8 random narrow read");
        else             rd(int'($urandom % 8) + 1, "R5 R6 random read");
      end else if (r == 7) begin
        access(1'b1, 1'b1, 0, narrow_mode ? 1 : 2, 16'($urandom), "R7 random data write");
      end else begin
        access(1'($urandom), 1'($urandom), int'($urandom % 8),
               int'($urandom % 10), 16'($urandom % 20), "R9 random request");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule